// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is an I2C/SMBus-compatible slave that connects an external register file to a two-wire bus. It runs from a system clock at least 16 times the SCL rate. SCL, SDA and the strap pins pass through multi-flop synchronizers. Bus conditions and SCL edges are then found by comparing consecutive synchronized samples. The slave answers to a 7-bit address. The upper bits come from a parameter. The low bits are taken from strap pins, and they are captured again at every START and repeated START. This lets a board change the device address between transfers.

In a write transfer, the first byte after the address sets the register pointer. Each later byte is written at the pointer, and the pointer then advances. In a read transfer, the slave returns the byte at the pointer, most significant bit first, and the pointer advances after every byte. This goes on while the master ACKs, and stops when it NACKs. A repeated START keeps the transaction open, so a pointer write can be followed directly by a read. A STOP ends any transfer at any point. The one exception is a STOP in the same SCL high pulse as the START, which is ignored.

Top module: `i2c_strap_slave`

## Requirements
- R1: A START (SDA falling while SCL high) or repeated START begins a new frame. When the following address byte matches, the slave holds SDA low for the whole ninth SCL pulse.
- R2: An address byte is 7 address bits followed by R/W in bit 0 (0 = write, 1 = read). Address bits 7..3 must equal ADDR_HI, and bits 2..1 must equal the strap pins captured at the most recent START. A strap change after that START has no effect until the next START.
- R3: A mismatching address is not acknowledged. The slave then keeps SDA released and writes nothing until the next START.
- R4: In a write frame, the first byte after the address loads the register pointer. Each following byte is written to the register file at the pointer. The slave ACKs every byte it receives.
- R5: The pointer advances by one after each byte written or read, and wraps from 2^AW-1 to 0.
- R6: In a read frame, the slave drives the byte at the pointer MSB first. It sends the next byte when the master ACKs. After a NACK it releases SDA and stays idle.
- R7: A STOP (SDA rising while SCL high) returns the slave to idle at any point of a frame. A byte cut off by a STOP is never written.
- R8: A STOP inside the same SCL high pulse as the START is ignored, and the frame continues.
- R9: The SDA output enable changes only while SCL is low.
- R10: After reset, SDA is released and no register-file write or read strobe is asserted.
- R11: A repeated START after a pointer write, followed by a read address, returns data starting at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line as seen at the pin |
| sda_in | input | 1 | SDA line as seen at the pin |
| strap_in | input | STRAP_W | Strap pins that give the low address bits |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | AW | Register pointer, used for both reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle strobe when a read byte is taken |
| reg_rd_data | input | 8 | Register contents at reg_addr |

## Verification
The hardest cases to reach are conditions the bus only shows in unusual pulse shapes. One is a STOP placed inside the same SCL high pulse as its START. Another is a strap change that lands after a START but before the address byte ends. The bench drives SCL and SDA directly through its own bit-level tasks, so it can build these shapes: a START and STOP with no SCL low between them, a STOP cut into the middle of a data byte, and strap edits timed between address bits. A per-clock model of the expected SDA enable in every SCL high phase catches any stray drive.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
   } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int W       = 4,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_now,
   output logic [W-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q_prev <= RST_VAL;
      else        q_prev <= chain[STAGES-1];

   assign q_now = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
   parameter int STRAP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_s,
   input  logic               scl_p,
   input  logic               sda_s,
   input  logic               sda_p,
   input  logic [STRAP_W-1:0] strap_s,
   output logic               scl_rise,
   output logic               scl_fall,
   output logic               start_ev,
   output logic               stop_ev,
   output logic [STRAP_W-1:0] strap_q
);
   logic in_start_pulse;
   logic stop_raw;

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_raw = scl_s & scl_p & ~sda_p & sda_s;
   assign stop_ev  = stop_raw & ~in_start_pulse;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         in_start_pulse <= 1'b0;
         strap_q        <= '0;
      end else begin
         if (start_ev) begin
            in_start_pulse <= 1'b1;
            strap_q        <= strap_s;
         end else if (!scl_s) begin
            in_start_pulse <= 1'b0;
         end
      end

   // a STOP while the START pulse is still high must not be reported
   assert_same_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev) |=> !stop_ev);
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> ptr == AW'($past(ptr) + 1'b1));
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
   import i2c_strap_pkg::*;
#(
   parameter int AW          = 8,
   parameter int STRAP_W     = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [6-STRAP_W:0] ADDR_HI = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap_in,
   output logic               sda_oe,
   output logic [AW-1:0]      reg_addr,
   output logic               reg_wr_en,
   output logic [7:0]         reg_wr_data,
   output logic               reg_rd_en,
   input  logic [7:0]         reg_rd_data
);
   localparam int SW = STRAP_W + 2;
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
      $error("i2c_strap_slave: AW must be 1..8");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("i2c_strap_slave: STRAP_W must be 1..6");
   end

   logic [SW-1:0] raw_in, sync_now, sync_prev;
   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic [STRAP_W-1:0] strap_q;

   assign raw_in = {strap_in, sda_in, scl_in};

   i2c_line_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_now(sync_now), .q_prev(sync_prev));

   assign scl_s = sync_now[0];
   assign sda_s = sync_now[1];

   i2c_bus_events #(.STRAP_W(STRAP_W)) u_events (
      .clk(clk), .rst_n(rst_n),
      .scl_s(scl_s), .scl_p(sync_prev[0]), .sda_s(sda_s), .sda_p(sync_prev[1]),
      .strap_s(sync_now[SW-1:2]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .strap_q(strap_q));

   slv_state_t state;
   logic [3:0] bit_cnt;
   logic [7:0] rx_sh, tx_sh;
   logic rw_q, ptr_first, mst_ack, oe_q, wr_q, rd_q, ld_q;
   logic [7:0] wr_data_q;
   logic [AW-1:0] ld_val_q;

   i2c_reg_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ld_q), .load_val(ld_val_q),
      .inc(wr_q | rd_q), .ptr(reg_addr));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state <= ST_IDLE; bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0;
         rw_q <= 1'b0; ptr_first <= 1'b0; mst_ack <= 1'b0; oe_q <= 1'b0;
         wr_q <= 1'b0; rd_q <= 1'b0; ld_q <= 1'b0; wr_data_q <= '0; ld_val_q <= '0;
      end else begin
         wr_q <= 1'b0; rd_q <= 1'b0; ld_q <= 1'b0;
         if (start_ev) begin
            state <= ST_ADDR; bit_cnt <= '0; oe_q <= 1'b0;
         end else if (stop_ev) begin
            state <= ST_IDLE; oe_q <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise && bit_cnt < LAST_BIT) begin
                     rx_sh   <= {rx_sh[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (state == ST_ADDR) begin
                        if (rx_sh[7:1] == {ADDR_HI, strap_q}) begin
                           oe_q <= 1'b1; rw_q <= rx_sh[0]; state <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        oe_q <= 1'b1; state <= ST_WR_ACK;
                        if (ptr_first) begin
                           ld_q <= 1'b1; ld_val_q <= rx_sh[AW-1:0]; ptr_first <= 1'b0;
                        end else begin
                           wr_q <= 1'b1; wr_data_q <= rx_sh;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     tx_sh <= reg_rd_data; oe_q <= ~reg_rd_data[7]; rd_q <= 1'b1;
                     state <= ST_RD;
                  end else begin
                     oe_q <= 1'b0; ptr_first <= 1'b1; state <= ST_WR;
                  end
               end
               ST_WR_ACK: if (scl_fall) begin
                  oe_q <= 1'b0; bit_cnt <= '0; state <= ST_WR;
               end
               ST_RD: if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     oe_q <= 1'b0; state <= ST_RD_ACK;
                  end else begin
                     oe_q    <= ~tx_sh[6];
                     tx_sh   <= {tx_sh[6:0], 1'b0};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) mst_ack <= ~sda_s;
                  else if (scl_fall) begin
                     bit_cnt <= '0;
                     if (mst_ack) begin
                        tx_sh <= reg_rd_data; oe_q <= ~reg_rd_data[7]; rd_q <= 1'b1;
                        state <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end

   assign sda_oe      = oe_q;
   assign reg_wr_en   = wr_q;
   assign reg_wr_data = wr_data_q;
   assign reg_rd_en   = rd_q;

   assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !$past(scl_s));
   assert_start_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state == ST_ADDR && bit_cnt == 4'd0));
   assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !oe_q);
   assert_write_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> (oe_q && state == ST_WR_ACK));
   assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && !start_ev) |=> (state == ST_IDLE && !oe_q));
   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_q && rd_q));
endmodule

// File: tb/i2c_strap_slave_test.sv
`timescale 1ns/1ps
module i2c_strap_slave_test;
   localparam logic [4:0] DEV_HI = 5'b10110;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] strap = 2'b01;
   logic sda_oe, reg_wr_en, reg_rd_en;
   logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
   logic sda_line;

   logic [7:0] rf  [256];
   logic [7:0] mdl [256];

   int checks = 0, errors = 0;
   int exp_oe = -1;
   string mon_req = "R9";
   bit done = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_strap_slave #(.AW(8), .STRAP_W(2), .SYNC_STAGES(2), .ADDR_HI(DEV_HI)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .strap_in(strap),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data));

   // device-side register file owned by the bench
   always @(posedge clk) if (reg_wr_en) rf[reg_addr] <= reg_wr_data;
   assign reg_rd_data = rf[reg_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference: in every SCL high phase the slave's enable must match the model
   always @(negedge clk)
      if (rst_n && scl_m && exp_oe >= 0 && !done)
         check(sda_oe == exp_oe[0], mon_req, sda_oe, exp_oe);

   task automatic wclk(input int n); repeat (n) @(posedge clk); endtask

   task automatic i2c_start();
      exp_oe = 0; sda_m = 1; wclk(Q); scl_m = 1; wclk(Q);
      sda_m = 0; wclk(Q); scl_m = 0; wclk(Q);
   endtask

   task automatic i2c_stop();
      exp_oe = 0; sda_m = 0; wclk(Q); scl_m = 1; wclk(Q); sda_m = 1; wclk(2*Q);
   endtask

   task automatic mbit(input bit b);
      sda_m = b; wclk(Q); scl_m = 1; wclk(2*Q); scl_m = 0; wclk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      logic got;
      exp_oe = 0; mon_req = req;
      for (int i = 7; i >= 0; i--) mbit(b[i]);
      sda_m = 1; exp_oe = exp_ack; wclk(Q); scl_m = 1; wclk(Q);
      got = sda_line; wclk(Q); scl_m = 0; wclk(Q);
      check(got == !exp_ack, req, got, !exp_ack);
      exp_oe = 0;
   endtask

   task automatic recv_byte(input logic [7:0] e, input bit ack, input string req);
      logic [7:0] got;
      mon_req = req;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1; exp_oe = !e[i]; wclk(Q); scl_m = 1; wclk(Q);
         got[i] = sda_line; wclk(Q); scl_m = 0; wclk(Q);
      end
      check(got == e, req, got, e);
      exp_oe = 0; sda_m = !ack; wclk(Q); scl_m = 1; wclk(2*Q); scl_m = 0; wclk(Q);
      sda_m = 1;
   endtask

   function automatic logic [7:0] ab(input logic [1:0] lo, input bit rd);
      return {DEV_HI, lo, rd};
   endfunction

   task automatic write_frame(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1);
      i2c_start();
      send_byte(ab(strap, 0), 1, "R1");
      send_byte(p, 1, "R4");
      send_byte(d0, 1, "R4"); mdl[p] = d0;
      send_byte(d1, 1, "R5"); mdl[8'(p + 1)] = d1;
      i2c_stop();
   endtask

   task automatic compare_all(input string req);
      int bad = 0, first = -1;
      for (int i = 0; i < 256; i++) if (rf[i] !== mdl[i]) begin bad++; if (first < 0) first = i; end
      if (first < 0) first = 0;
      check(bad == 0, req, rf[first], mdl[first]);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin rf[i] = 8'(i * 7 + 3); mdl[i] = 8'(i * 7 + 3); end
      wclk(5);
      // R10: reset state
      check(sda_oe == 0, "R10", sda_oe, 0);
      check(reg_wr_en == 0 && reg_rd_en == 0, "R10", {reg_wr_en, reg_rd_en}, 0);
      rst_n = 1; wclk(10);

      // R4/R5: pointer then two data bytes
      write_frame(8'h10, 8'hA5, 8'h3C);
      check(rf[8'h10] == 8'hA5, "R4", rf[8'h10], 8'hA5);
      check(rf[8'h11] == 8'h3C, "R5", rf[8'h11], 8'h3C);

      // R11/R6: pointer write, repeated START, read three bytes, NACK last
      i2c_start();
      send_byte(ab(strap, 0), 1, "R1");
      send_byte(8'h10, 1, "R11");
      i2c_start();
      send_byte(ab(strap, 1), 1, "R11");
      recv_byte(mdl[8'h10], 1, "R6");
      recv_byte(mdl[8'h11], 1, "R6");
      recv_byte(mdl[8'h12], 0, "R6");
      mon_req = "R6"; wclk(4*Q);
      i2c_stop();

      // R5: wrap of the pointer
      write_frame(8'hFF, 8'h11, 8'h22);
      check(rf[8'hFF] == 8'h11, "R5", rf[8'hFF], 8'h11);
      check(rf[8'h00] == 8'h22, "R5", rf[8'h00], 8'h22);

      // R3: mismatching low bits, then data that must be ignored
      i2c_start();
      send_byte(ab(2'b10, 0), 0, "R3");
      send_byte(8'h01, 0, "R3");
      send_byte(8'hEE, 0, "R3");
      i2c_stop();
      compare_all("R3");

      // R2: strap edited after START does not matter
      strap = 2'b10; wclk(Q);
      i2c_start();
      strap = 2'b01;
      send_byte(ab(2'b10, 0), 1, "R2");
      send_byte(8'h20, 1, "R2");
      send_byte(8'h5A, 1, "R2"); mdl[8'h20] = 8'h5A;
      i2c_stop();
      check(rf[8'h20] == 8'h5A, "R2", rf[8'h20], 8'h5A);
      // R2: the new strap value applies from the next START
      i2c_start();
      send_byte(ab(2'b10, 0), 0, "R2");
      i2c_stop();
      i2c_start();
      send_byte(ab(2'b01, 0), 1, "R2");
      i2c_stop();

      // R7: STOP inside a data byte
      i2c_start();
      send_byte(ab(strap, 0), 1, "R1");
      send_byte(8'h30, 1, "R7");
      mon_req = "R7";
      mbit(1); mbit(0); mbit(1); mbit(1);
      i2c_stop();
      scl_m = 0; wclk(Q);
      for (int i = 0; i < 6; i++) mbit(i[0]);
      sda_m = 1; wclk(Q); scl_m = 1; wclk(2*Q);
      check(rf[8'h30] == mdl[8'h30], "R7", rf[8'h30], mdl[8'h30]);

      // R8: STOP within the START's SCL high pulse is ignored
      exp_oe = 0; mon_req = "R8";
      sda_m = 0; wclk(Q); sda_m = 1; wclk(Q); scl_m = 0; wclk(Q);
      send_byte(ab(strap, 0), 1, "R8");
      send_byte(8'h40, 1, "R8");
      send_byte(8'h77, 1, "R8"); mdl[8'h40] = 8'h77;
      i2c_stop();
      check(rf[8'h40] == 8'h77, "R8", rf[8'h40], 8'h77);

      compare_all("R4");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wclk(200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule